// File: doc/BRIEF.md
# Multi-Polynomial CRC Accumulator

This block keeps a running CRC remainder for a packet-processing core. Each cycle it can take one 32-bit data word and fold it into the stored remainder. A 3-bit mode input chooses the polynomial and the width for that word: a 16-bit check, the common 32-bit check, the Castagnoli 32-bit variant used for storage traffic, a 10-bit check for ATM maintenance cells, or a 5-bit check for ATM adaptation-layer headers. All five variants share one remainder register, so software can switch between them from one word to the next.

Software first loads a start value through the load port, then streams data words with a valid strobe, and reads the remainder on the output. Bits are taken most significant first. Bits are not reflected and no final XOR is applied. The remainder of a narrow CRC sits in the low bits of the register, and the bits above it read as zero.

Top module: `crc_fold_unit`

## Requirements
- R1: After reset the remainder output `crc_out` is 0.
- R2: With `mode` = 0 a valid word is folded with the 16-bit polynomial 0x1021.
- R3: With `mode` = 1 a valid word is folded with the 32-bit polynomial 0x04C11DB7.
- R4: With `mode` = 2 a valid word is folded with the 32-bit Castagnoli polynomial 0x1EDC6F41.
- R5: With `mode` = 3 a valid word is folded with the 10-bit polynomial 0x233.
- R6: With `mode` = 4 a valid word is folded with the 5-bit polynomial 0x05.
- R7: A word is processed bit 31 first, with no reflection and no output XOR. The new remainder is on `crc_out` in the cycle after the word. Words on consecutive cycles chain with no gap.
- R8: After a load or a fold in a mode of width W, bits 31 down to W of `crc_out` are 0. A fold uses only the low W bits of the previous remainder.
- R9: When `ld_en` is high with a known mode, the next remainder is `ld_val` masked to that mode's width. A data word presented in the same cycle is dropped.
- R10: For mode codes 5, 6 and 7, neither a load nor a data word changes the remainder.
- R11: With `ld_en` and `word_vld` both low, the remainder holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load the remainder from `ld_val` |
| ld_val | input | 32 | Start value to load |
| word_vld | input | 1 | A data word is present on `word` |
| word | input | 32 | Data word, bit 31 taken first |
| mode | input | 3 | Polynomial select (0 to 4). Applies to both load and fold |
| crc_out | output | 32 | Current remainder, zero-extended |

## Verification
The hardest case to reach is a remainder left by a wide mode, with its upper bits set, that is then folded in a narrow mode. The narrow fold must use only the low bits and must clear everything above them. The stimulus loads all ones in 32-bit mode and then presents words in the 5-bit and 10-bit modes. It also chains words in one mode on back-to-back cycles, each checked against a model written in top-aligned form. Load and data word are asserted in the same cycle to show that the load wins, and every input is driven with unknown mode codes to show that they have no effect.

// File: rtl/crc_fold_pkg.sv
package crc_fold_pkg;

  localparam int DATA_W    = 32;
  localparam int NUM_MODES = 5;
  localparam int MODE_W    = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_C16  = 3'd0,
    MODE_C32  = 3'd1,
    MODE_C32C = 3'd2,
    MODE_C10  = 3'd3,
    MODE_C5   = 3'd4
  } crc_mode_e;

  // width of the remainder for a mode index
  function automatic int mode_width(input int m);
    case (m)
      0:       return 16;
      1:       return 32;
      2:       return 32;
      3:       return 10;
      4:       return 5;
      default: return 32;
    endcase
  endfunction

  // generator polynomial without its leading term
  function automatic logic [DATA_W-1:0] mode_poly(input int m);
    case (m)
      0:       return 32'h0000_1021;
      1:       return 32'h04C1_1DB7;
      2:       return 32'h1EDC_6F41;
      3:       return 32'h0000_0233;
      4:       return 32'h0000_0005;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] width_mask(input int w);
    if (w >= DATA_W) return '1;
    return (DATA_W'(1) << w) - DATA_W'(1);
  endfunction

  // serial shift register unrolled over one word, MSB first
  function automatic logic [DATA_W-1:0] fold_word(input logic [DATA_W-1:0] rem_in,
                                                  input logic [DATA_W-1:0] data,
                                                  input int w,
                                                  input logic [DATA_W-1:0] poly);
    logic [DATA_W-1:0] r;
    logic [DATA_W-1:0] msk;
    logic fb;
    msk = width_mask(w);
    r   = rem_in & msk;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = r[w-1] ^ data[i];
      r  = (r << 1) & msk;
      if (fb) r = r ^ poly;
    end
    return r & msk;
  endfunction

endpackage

// File: rtl/crc_lane.sv
module crc_lane
  import crc_fold_pkg::*;
#(
  parameter int                WIDTH = 32,
  parameter logic [DATA_W-1:0] POLY  = 32'h04C1_1DB7
) (
  input  logic [DATA_W-1:0] rem_in,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] rem_next
);
  always_comb begin
    rem_next = fold_word(rem_in, data, WIDTH, POLY);
  end
endmodule

// File: rtl/crc_mode_mux.sv
module crc_mode_mux
  import crc_fold_pkg::*;
#(
  parameter int LANES = NUM_MODES
) (
  input  logic [LANES-1:0][DATA_W-1:0] lane_next,
  input  logic [MODE_W-1:0]            mode,
  input  logic [DATA_W-1:0]            hold_val,
  output logic [DATA_W-1:0]            sel_next
);
  always_comb begin
    sel_next = hold_val;
    for (int i = 0; i < LANES; i++) begin
      if (mode == MODE_W'(i)) sel_next = lane_next[i];
    end
  end
endmodule

// File: rtl/crc_rem_store.sv
module crc_rem_store
  import crc_fold_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_fire,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              upd_fire,
  input  logic [DATA_W-1:0] upd_data,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        q <= '0;
    else if (ld_fire)  q <= ld_data;
    else if (upd_fire) q <= upd_data;
  end
endmodule

// File: rtl/crc_fold_unit.sv
module crc_fold_unit
  import crc_fold_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [DATA_W-1:0] ld_val,
  input  logic              word_vld,
  input  logic [DATA_W-1:0] word,
  input  logic [MODE_W-1:0] mode,
  output logic [DATA_W-1:0] crc_out
);
  localparam int LANES = NUM_MODES;

  logic [LANES-1:0][DATA_W-1:0] lane_next;
  logic [DATA_W-1:0]            fold_next;
  logic [DATA_W-1:0]            ld_masked;
  logic                         mode_known;
  logic                         load_fire;
  logic                         fold_fire;

  // named events, also observed by the checker
  assign mode_known = (mode < MODE_W'(LANES));
  assign load_fire  = ld_en & mode_known;
  assign fold_fire  = word_vld & ~ld_en & mode_known;

  always_comb begin
    ld_masked = ld_val & width_mask(mode_width(int'(mode)));
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    crc_lane #(
      .WIDTH(mode_width(g)),
      .POLY (mode_poly(g))
    ) i_lane (
      .rem_in  (crc_out),
      .data    (word),
      .rem_next(lane_next[g])
    );
  end

  crc_mode_mux #(.LANES(LANES)) i_mux (
    .lane_next(lane_next),
    .mode     (mode),
    .hold_val (crc_out),
    .sel_next (fold_next)
  );

  crc_rem_store i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_fire (load_fire),
    .ld_data (ld_masked),
    .upd_fire(fold_fire),
    .upd_data(fold_next),
    .q       (crc_out)
  );
endmodule

// File: rtl/crc_fold_chk.sv
module crc_fold_chk
  import crc_fold_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ld_en,
  input logic [DATA_W-1:0] ld_val,
  input logic              word_vld,
  input logic [MODE_W-1:0] mode,
  input logic [DATA_W-1:0] crc_out,
  input logic              mode_known,
  input logic              load_fire,
  input logic              fold_fire
);
  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> crc_out == ($past(ld_val) & width_mask(mode_width(int'($past(mode))))));

  assert_upper_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fire || fold_fire) |=>
      ((crc_out & ~width_mask(mode_width(int'($past(mode))))) == '0));

  assert_bad_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_known) |=> $stable(crc_out));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !word_vld) |=> $stable(crc_out));

  assert_events_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_fire && fold_fire));
endmodule

bind crc_fold_unit crc_fold_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_en     (ld_en),
  .ld_val    (ld_val),
  .word_vld  (word_vld),
  .mode      (mode),
  .crc_out   (crc_out),
  .mode_known(mode_known),
  .load_fire (load_fire),
  .fold_fire (fold_fire)
);

// File: tb/test_crc_fold_unit.sv
module test_crc_fold_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [31:0] ld_val = '0;
  logic        word_vld = 1'b0;
  logic [31:0] word = '0;
  logic [2:0]  mode = '0;
  logic [31:0] crc_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  crc_fold_unit i_crc_fold_unit (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_val(ld_val),
    .word_vld(word_vld), .word(word), .mode(mode), .crc_out(crc_out)
  );

  // top-aligned model: remainder shifted up to bit 31
  function automatic logic [31:0] model(input logic [31:0] rem, input logic [31:0] w,
                                        input int m);
    int          wd;
    logic [31:0] p;
    logic [31:0] r;
    logic [31:0] pt;
    logic        top;
    case (m)
      0: begin wd = 16; p = 32'h1021;      end
      1: begin wd = 32; p = 32'h04C11DB7;  end
      2: begin wd = 32; p = 32'h1EDC6F41;  end
      3: begin wd = 10; p = 32'h233;       end
      4: begin wd = 5;  p = 32'h05;        end
      default: return rem;
    endcase
    r  = rem << (32 - wd);
    pt = p << (32 - wd);
    for (int i = 31; i >= 0; i--) begin
      top = r[31] ^ w[i];
      r   = r << 1;
      if (top) r = r ^ pt;
    end
    return r >> (32 - wd);
  endfunction

  function automatic logic [31:0] lowmask(input int m);
    case (m)
      0: return 32'h0000FFFF;
      3: return 32'h000003FF;
      4: return 32'h0000001F;
      default: return 32'hFFFFFFFF;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic step(input logic l, input logic [31:0] lv, input logic v,
                      input logic [31:0] w, input logic [2:0] m);
    @(negedge clk);
    ld_en = l; ld_val = lv; word_vld = v; word = w; mode = m;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(1'b0, 32'h0, 1'b0, 32'h0, 3'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 reset value", crc_out, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // word 1 from zero yields exactly the polynomial
  task automatic t_single_bit();
    string tags[5] = '{"R2", "R3", "R4", "R5", "R6"};
    logic [31:0] polys[5] = '{32'h1021, 32'h04C11DB7, 32'h1EDC6F41, 32'h233, 32'h05};
    for (int m = 0; m < 5; m++) begin
      step(1'b1, 32'h0, 1'b0, 32'h0, 3'(m));
      step(1'b0, 32'h0, 1'b1, 32'h1, 3'(m));
      chk({tags[m], " lsb-only word gives poly"}, crc_out, polys[m]);
    end
  endtask

  // back-to-back words in each mode against the model
  task automatic t_stream();
    string tags[5] = '{"R2", "R3", "R4", "R5", "R6"};
    logic [31:0] words[4] = '{32'h31323334, 32'hDEADBEEF, 32'h80000000, 32'h0F0F5AA5};
    logic [31:0] exp;
    for (int m = 0; m < 5; m++) begin
      step(1'b1, 32'hFFFFFFFF, 1'b0, 32'h0, 3'(m));
      exp = 32'hFFFFFFFF & lowmask(m);
      for (int k = 0; k < 4; k++) begin
        step(1'b0, 32'h0, 1'b1, words[k], 3'(m));
        exp = model(exp, words[k], m);
        chk({tags[m], " R7 chained word"}, crc_out, exp);
      end
    end
  endtask

  // wide remainder with upper bits set, then narrow modes
  task automatic t_narrow_after_wide();
    logic [31:0] exp;
    step(1'b1, 32'hFFFFFFFF, 1'b0, 32'h0, 3'd1);
    chk("R9 full-width load", crc_out, 32'hFFFFFFFF);
    step(1'b0, 32'h0, 1'b1, 32'h12345678, 3'd4);
    exp = model(32'h1F, 32'h12345678, 4);
    chk("R8 5-bit fold after 32-bit remainder", crc_out, exp);
    chk("R8 upper bits zero (5)", crc_out & ~32'h1F, 32'h0);
    step(1'b1, 32'hFFFFFFFF, 1'b0, 32'h0, 3'd2);
    step(1'b0, 32'h0, 1'b1, 32'hCAFEF00D, 3'd3);
    exp = model(32'h3FF, 32'hCAFEF00D, 3);
    chk("R8 10-bit fold after 32-bit remainder", crc_out, exp);
    chk("R8 upper bits zero (10)", crc_out & ~32'h3FF, 32'h0);
  endtask

  task automatic t_load_priority();
    step(1'b1, 32'hA5A5_1234, 1'b1, 32'hFFFF_FFFF, 3'd1);
    chk("R9 load beats word", crc_out, 32'hA5A51234);
    step(1'b1, 32'hFFFF_FFFF, 1'b1, 32'h1, 3'd4);
    chk("R9 load masked to 5 bits", crc_out, 32'h0000001F);
    step(1'b1, 32'hABCD_9876, 1'b0, 32'h0, 3'd0);
    chk("R9 load masked to 16 bits", crc_out, 32'h00009876);
  endtask

  task automatic t_bad_mode();
    step(1'b1, 32'h1357_9BDF, 1'b0, 32'h0, 3'd2);
    step(1'b1, 32'hFFFF_0000, 1'b0, 32'h0, 3'd5);
    chk("R10 load with code 5 ignored", crc_out, 32'h13579BDF);
    step(1'b0, 32'h0, 1'b1, 32'h89AB_CDEF, 3'd6);
    chk("R10 word with code 6 ignored", crc_out, 32'h13579BDF);
    step(1'b1, 32'h0, 1'b1, 32'hFFFF_FFFF, 3'd7);
    chk("R10 load and word with code 7 ignored", crc_out, 32'h13579BDF);
  endtask

  task automatic t_idle_hold();
    step(1'b1, 32'h2468_ACE0, 1'b0, 32'h0, 3'd1);
    idle();
    idle();
    step(1'b0, 32'h0, 1'b0, 32'hFFFF_FFFF, 3'd3);
    chk("R11 hold with no strobe", crc_out, 32'h2468ACE0);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", crc_out, 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_single_bit();
    t_stream();
    t_narrow_after_wide();
    t_load_priority();
    t_bad_mode();
    t_idle_hold();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule